// File: doc/BRIEF.md
# Gauss-Seidel Relaxation Engine for the 2D Poisson Stencil

This engine relaxes a square grid held in an on-chip RAM with the five-point Poisson stencil. It updates points in place, so each sweep reuses values that the same sweep has already written. The grid side is N = 2^L + 2 points. The outer ring holds boundary values and the engine never changes it. After a start pulse the engine runs the requested number of sweeps over the interior. It then raises done for one cycle. The same datapath serves both smoothing steps of a multigrid level, the one before descending to a coarser grid and the one after the correction returns.

A mode input points the stencil datapath at a second job. In that mode the engine makes one pass that writes the residual f − A·u into a separate residual RAM and leaves the solution untouched. This step comes before any transfer of the residual to a coarser grid. All three arrays live in RAMs outside the block. Reads return data one cycle after the address, and writes land on the clock edge that ends the write cycle.

Top module: `gs_smoother`

## Requirements
- R1: In smoothing mode each interior point becomes (up + down + left + right + ((h2 · f) >>> FRAC)) >>> 2. Values are signed DW-bit fixed point with FRAC fraction bits. Shifts are arithmetic, and the result wraps to DW bits.
- R2: Word address = i·N + j, where i is the row and j the column. Interior points are visited row by row, top to bottom, and left to right within a row. A point reads its neighbours only after earlier points of the same sweep have been written, so fresh values feed later points.
- R3: No address whose row or column is 0 or N−1 is ever written, in either RAM.
- R4: A smoothing run with sweep count S > 0 performs S full passes, which is exactly S·(N−2)² solution writes.
- R5: In residual mode each interior point writes f − (((4·centre − up − down − left − right) · inv_h2) >>> FRAC), wrapped to DW bits, to the residual RAM at the point's address. This takes exactly one pass for any non-zero sweep count, and the solution RAM is not written.
- R6: done is high for exactly one cycle. It rises in the cycle after the last write cycle and lies 8·(N−2)²·passes + 1 cycles after the cycle in which start was sampled.
- R7: A sweep count of zero raises done in the cycle after start, in either mode, with no write to either RAM.
- R8: start is ignored while a run is in progress and in the cycle when done is high. Such a pulse causes no extra writes, no second done and no change of result.
- R9: After reset, done and both write enables are low and the engine waits for start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled when idle) |
| mode_resid | input | 1 | 0 = smooth in place, 1 = residual pass |
| sweeps | input | SWW | Number of smoothing passes |
| h2 | input | DW | Mesh spacing squared, signed fixed point |
| inv_h2 | input | DW | Reciprocal of mesh spacing squared, signed fixed point |
| u_raddr | output | AW | Solution RAM read address |
| u_rdata | input | DW | Solution RAM read data (one cycle latency) |
| u_we | output | 1 | Solution RAM write enable |
| u_waddr | output | AW | Solution RAM write address |
| u_wdata | output | DW | Solution RAM write data |
| f_raddr | output | AW | Right-hand-side RAM read address |
| f_rdata | input | DW | Right-hand-side RAM read data (one cycle latency) |
| r_we | output | 1 | Residual RAM write enable |
| r_waddr | output | AW | Residual RAM write address |
| r_wdata | output | DW | Residual RAM write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle. One is a new start pulse, which can arrive mid-run or exactly in the done cycle. The other is the engine's own completion. The bench provokes both. During one smoothing run it injects a start with a different mode and sweep count. It then drives another start at the negative edge where done is seen high. The run passes only if the write count, the final grid, the done latency and the single done pulse all match a run with no extra pulse. The hand-off between a point's write and the next point's reads is judged by comparing every grid value against an in-order reference model.

// File: rtl/gs_pkg.sv
package gs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_WR,
    ST_DONE
  } gs_state_e;

  // order in which the stencil operands are fetched
  localparam int NB_UP  = 0;
  localparam int NB_LF  = 1;
  localparam int NB_RT  = 2;
  localparam int NB_DN  = 3;
  localparam int NB_CT  = 4;
  localparam int NB_CNT = 5;

  function automatic int grid_side(input int lvl);
    return (1 << lvl) + 2;
  endfunction

endpackage

// File: rtl/gs_walker.sv
module gs_walker #(
  parameter int N   = 6,
  parameter int SWW = 8,
  parameter int IW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [SWW-1:0] load_cnt,
  input  logic           advance,
  output logic [IW-1:0]  row,
  output logic [IW-1:0]  col,
  output logic           last_point,
  output logic           last_sweep
);

  localparam logic [IW-1:0] FIRST = IW'(1);
  localparam logic [IW-1:0] LAST  = IW'(N - 2);

  logic [SWW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row    <= FIRST;
      col    <= FIRST;
      left_q <= '0;
    end else if (load) begin
      row    <= FIRST;
      col    <= FIRST;
      left_q <= load_cnt;
    end else if (advance) begin
      if (col == LAST) begin
        col <= FIRST;
        if (row == LAST) begin
          row    <= FIRST;
          left_q <= left_q - SWW'(1);
        end else begin
          row <= row + IW'(1);
        end
      end else begin
        col <= col + IW'(1);
      end
    end
  end

  assign last_point = (row == LAST) && (col == LAST);
  assign last_sweep = (left_q == SWW'(1));

  // a sweep may only end while at least one pass is still owed
  assert_sweep_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (advance && last_point) |-> (left_q != '0));

  assert_walk_inside_R3: assert property (@(posedge clk) disable iff (rst)
    advance |-> (row >= FIRST && row <= LAST && col >= FIRST && col <= LAST));

endmodule

// File: rtl/gs_stencil.sv
module gs_stencil #(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic signed [DW-1:0] up,
  input  logic signed [DW-1:0] dn,
  input  logic signed [DW-1:0] lf,
  input  logic signed [DW-1:0] rt,
  input  logic signed [DW-1:0] ct,
  input  logic signed [DW-1:0] f,
  input  logic signed [DW-1:0] h2,
  input  logic signed [DW-1:0] inv_h2,
  input  logic                 resid,
  output logic        [DW-1:0] result
);

  localparam int PW = 2 * DW + 4;

  logic signed [PW-1:0] sum, rhs, smooth, lap, scaled, res;

  always_comb begin
    sum    = PW'(up) + PW'(dn) + PW'(lf) + PW'(rt);
    rhs    = (PW'(h2) * PW'(f)) >>> FRAC;
    smooth = (sum + rhs) >>> 2;
    lap    = (PW'(ct) <<< 2) - sum;
    scaled = (lap * PW'(inv_h2)) >>> FRAC;
    res    = PW'(f) - scaled;
    result = resid ? res[DW-1:0] : smooth[DW-1:0];
  end

endmodule

// File: rtl/gs_smoother.sv
module gs_smoother #(
  parameter int L    = 2,
  parameter int DW   = 16,
  parameter int FRAC = 8,
  parameter int SWW  = 8,
  localparam int N   = gs_pkg::grid_side(L),
  localparam int AW  = $clog2(N * N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           mode_resid,
  input  logic [SWW-1:0] sweeps,
  input  logic [DW-1:0]  h2,
  input  logic [DW-1:0]  inv_h2,
  output logic [AW-1:0]  u_raddr,
  input  logic [DW-1:0]  u_rdata,
  output logic           u_we,
  output logic [AW-1:0]  u_waddr,
  output logic [DW-1:0]  u_wdata,
  output logic [AW-1:0]  f_raddr,
  input  logic [DW-1:0]  f_rdata,
  output logic           r_we,
  output logic [AW-1:0]  r_waddr,
  output logic [DW-1:0]  r_wdata,
  output logic           done
);
  import gs_pkg::*;

  localparam int IW = $clog2(N);
  localparam logic [AW-1:0] NA  = AW'(N);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [2:0]    PH_CALC = 3'd6;

  gs_state_e st;
  logic [2:0]    ph;
  logic          mode_q;
  logic [DW-1:0] nb [NB_CNT];
  logic [DW-1:0] f_q;
  logic [AW-1:0] waddr_q;
  logic [DW-1:0] wdata_q;

  logic [IW-1:0] row, col;
  logic          last_point, last_sweep;
  logic          load, advance;
  logic [AW-1:0] ctr;
  logic [DW-1:0] alu_out;

  assign load    = (st == ST_IDLE) && start && (sweeps != '0);
  assign advance = (st == ST_WR);

  gs_walker #(.N(N), .SWW(SWW), .IW(IW)) i_walk (
    .clk(clk), .rst(rst), .load(load),
    .load_cnt(mode_resid ? SWW'(1) : sweeps),
    .advance(advance), .row(row), .col(col),
    .last_point(last_point), .last_sweep(last_sweep)
  );

  assign ctr = AW'(row) * NA + AW'(col);

  // operand fetch order follows the NB_* indices
  always_comb begin
    case (ph)
      3'd0:    u_raddr = ctr - NA;
      3'd1:    u_raddr = ctr - ONE;
      3'd2:    u_raddr = ctr + ONE;
      3'd3:    u_raddr = ctr + NA;
      default: u_raddr = ctr;
    endcase
  end
  assign f_raddr = ctr;

  gs_stencil #(.DW(DW), .FRAC(FRAC)) i_alu (
    .up(nb[NB_UP]), .dn(nb[NB_DN]), .lf(nb[NB_LF]), .rt(nb[NB_RT]),
    .ct(nb[NB_CT]), .f(f_q), .h2(h2), .inv_h2(inv_h2),
    .resid(mode_q), .result(alu_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      ph      <= '0;
      mode_q  <= 1'b0;
      f_q     <= '0;
      waddr_q <= '0;
      wdata_q <= '0;
      u_we    <= 1'b0;
      r_we    <= 1'b0;
      done    <= 1'b0;
      for (int k = 0; k < NB_CNT; k++) nb[k] <= '0;
    end else begin
      done <= 1'b0;
      u_we <= 1'b0;
      r_we <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          mode_q <= mode_resid;
          ph     <= '0;
          if (sweeps == '0) begin
            st   <= ST_DONE;
            done <= 1'b1;
          end else begin
            st <= ST_RUN;
          end
        end
        ST_RUN: begin
          ph <= ph + 3'd1;
          for (int k = 0; k < NB_CNT; k++)
            if (ph == 3'(k + 1)) nb[k] <= u_rdata;
          if (ph == 3'd1) f_q <= f_rdata;
          if (ph == PH_CALC) begin
            waddr_q <= ctr;
            wdata_q <= alu_out;
            u_we    <= !mode_q;
            r_we    <= mode_q;
            st      <= ST_WR;
          end
        end
        ST_WR: begin
          ph <= '0;
          if (last_point && last_sweep) begin
            st   <= ST_DONE;
            done <= 1'b1;
          end else begin
            st <= ST_RUN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign u_waddr = waddr_q;
  assign r_waddr = waddr_q;
  assign u_wdata = wdata_q;
  assign r_wdata = wdata_q;

  assert_one_target_R5: assert property (@(posedge clk) disable iff (rst)
    !(u_we && r_we));

  assert_mode_target_R5: assert property (@(posedge clk) disable iff (rst)
    (u_we |-> !mode_q) and (r_we |-> mode_q));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_zero_sweeps_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start && sweeps == '0) |=> (done && !u_we && !r_we));

  assert_interior_only_R3: assert property (@(posedge clk) disable iff (rst)
    (u_we || r_we) |-> (int'(waddr_q) % N != 0 && int'(waddr_q) % N != N - 1 &&
                        int'(waddr_q) / N != 0 && int'(waddr_q) / N != N - 1));

  // a write is never followed by another write, leaving room for read-back
  assert_write_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (u_we || r_we) |=> !(u_we || r_we));

endmodule

// File: tb/test_gs_smoother.sv
`timescale 1ns/1ps
module test_gs_smoother;
  localparam int L = 2, DW = 16, FRAC = 8, SWW = 8;
  localparam int N = (1 << L) + 2;
  localparam int NN = N * N;
  localparam int P = (N - 2) * (N - 2);
  localparam int AW = $clog2(NN);
  localparam logic [DW-1:0] SENT = 16'h5A5A;

  localparam int NV = 5;
  localparam int T_MODE [NV] = '{0, 0, 1, 1, 0};
  localparam int T_SW   [NV] = '{1, 3, 1, 4, 2};
  localparam int T_SEED [NV] = '{1, 2, 3, 4, 5};
  localparam int T_H2   [NV] = '{64, 32, 64, 64, -64};
  localparam int T_INV  [NV] = '{1024, 1024, 512, 1024, 1024};
  localparam int T_WR   [NV] = '{16, 48, 16, 16, 32};

  logic clk = 0, rst = 1;
  logic start = 0, mode_resid = 0;
  logic [SWW-1:0] sweeps = '0;
  logic [DW-1:0] h2 = '0, inv_h2 = '0;
  logic [AW-1:0] u_raddr, u_waddr, f_raddr, r_waddr;
  logic [DW-1:0] u_rdata, u_wdata, f_rdata, r_wdata;
  logic u_we, r_we, done;

  always #5 clk = ~clk;

  gs_smoother #(.L(L), .DW(DW), .FRAC(FRAC), .SWW(SWW)) i_gs_smoother (
    .clk(clk), .rst(rst), .start(start), .mode_resid(mode_resid),
    .sweeps(sweeps), .h2(h2), .inv_h2(inv_h2),
    .u_raddr(u_raddr), .u_rdata(u_rdata), .u_we(u_we), .u_waddr(u_waddr),
    .u_wdata(u_wdata), .f_raddr(f_raddr), .f_rdata(f_rdata),
    .r_we(r_we), .r_waddr(r_waddr), .r_wdata(r_wdata), .done(done)
  );

  // bench-side RAMs
  logic [DW-1:0] u_mem [NN];
  logic [DW-1:0] f_mem [NN];
  logic [DW-1:0] r_mem [NN];
  logic ld_we = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_u = '0, ld_f = '0;

  always @(posedge clk) begin
    if (ld_we) begin
      u_mem[ld_addr] <= ld_u;
      f_mem[ld_addr] <= ld_f;
      r_mem[ld_addr] <= SENT;
    end else begin
      if (u_we) u_mem[u_waddr] <= u_wdata;
      if (r_we) r_mem[r_waddr] <= r_wdata;
    end
    u_rdata <= u_mem[u_raddr];
    f_rdata <= f_mem[f_raddr];
  end

  // port monitor
  logic clr_mon = 0;
  int cyc = 0, wr_cnt = 0, done_cnt = 0, st_cyc = 0, done_cyc = 0, last_wr = 0;
  bit st_seen = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr_mon) begin
      wr_cnt <= 0; done_cnt <= 0; st_seen <= 0;
    end else begin
      if (start && !st_seen) begin st_seen <= 1; st_cyc <= cyc; end
      if (u_we || r_we) begin wr_cnt <= wr_cnt + 1; last_wr <= cyc; end
      if (done) begin done_cnt <= done_cnt + 1; done_cyc <= cyc; end
    end
  end

  int checks = 0, errs = 0;
  longint ref_u [NN];
  longint ref_f [NN];
  longint ref_r [NN];

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint wrap(input longint v);
    logic signed [DW-1:0] t;
    t = DW'(v);
    return longint'(t);
  endfunction

  task automatic load_grid(input int seed);
    for (int a = 0; a < NN; a++) begin
      int i = a / N, j = a % N;
      longint uv = longint'(((i * 7 + j * 13 + seed * 5) % 33 - 16) * 16);
      longint fv = longint'(((i * 11 + j * 3 + seed * 7) % 17 - 8) * 32);
      ref_u[a] = uv; ref_f[a] = fv; ref_r[a] = wrap(longint'(SENT));
      @(negedge clk);
      ld_we = 1; ld_addr = AW'(a); ld_u = DW'(uv); ld_f = DW'(fv);
    end
    @(negedge clk); ld_we = 0;
  endtask

  task automatic model(input int mode, input int s, input int h2v, input int invv);
    int passes = (s == 0) ? 0 : (mode != 0 ? 1 : s);
    for (int p = 0; p < passes; p++)
      for (int i = 1; i < N - 1; i++)
        for (int j = 1; j < N - 1; j++) begin
          int a = i * N + j;
          longint sm = ref_u[a - N] + ref_u[a + N] + ref_u[a - 1] + ref_u[a + 1];
          if (mode == 0)
            ref_u[a] = wrap((sm + ((longint'(h2v) * ref_f[a]) >>> FRAC)) >>> 2);
          else
            ref_r[a] = wrap(ref_f[a] - (((4 * ref_u[a] - sm) * longint'(invv)) >>> FRAC));
        end
  endtask

  task automatic run_case(input int mode, input int s, input int h2v, input int invv,
                          input bit poke, input int exp_wr, input string tag);
    bit got = 0;
    int passes = (s == 0) ? 0 : (mode != 0 ? 1 : s);
    @(negedge clk); clr_mon = 1;
    @(negedge clk); clr_mon = 0;
    mode_resid = mode[0]; sweeps = SWW'(s); h2 = DW'(h2v); inv_h2 = DW'(invv);
    start = 1;
    @(negedge clk); start = 0;
    for (int c = 0; c < 20000 && !got; c++) begin
      if (poke && c == 40) begin
        start = 1; sweeps = SWW'(5); mode_resid = ~mode_resid;
      end else start = 0;
      if (done) got = 1; else @(negedge clk);
    end
    if (poke) begin
      start = 1;                       // lands in the done cycle (R8)
      @(negedge clk); start = 0;
    end
    repeat (30) @(negedge clk);
    check({tag, " R6 done seen"}, longint'(got), 1);
    check({tag, " R4 write count"}, wr_cnt, exp_wr);
    check({tag, " R6 single done"}, done_cnt, 1);
    check({tag, " R6 latency"}, done_cyc - st_cyc, 8 * P * passes + 1);
    if (exp_wr > 0) check({tag, " R6 done after last write"}, done_cyc - last_wr, 1);
    model(mode, s, h2v, invv);
    for (int a = 0; a < NN; a++) begin
      check($sformatf("%s R1,R2,R3,R5 u[%0d]", tag, a), wrap(longint'(u_mem[a])), ref_u[a]);
      check($sformatf("%s R3,R5 r[%0d]", tag, a), wrap(longint'(r_mem[a])), ref_r[a]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9 done after reset", longint'(done), 0);
    check("R9 u_we after reset", longint'(u_we), 0);
    check("R9 r_we after reset", longint'(r_we), 0);

    for (int v = 0; v < NV; v++) begin
      load_grid(T_SEED[v]);
      run_case(T_MODE[v], T_SW[v], T_H2[v], T_INV[v], 0, T_WR[v],
               $sformatf("vec%0d", v));
    end

    // R7: zero sweep count, both modes
    load_grid(7);
    run_case(0, 0, 64, 1024, 0, 0, "R7 zero smooth");
    run_case(1, 0, 64, 1024, 0, 0, "R7 zero resid");

    // R8: start during the run and in the done cycle
    load_grid(6);
    run_case(0, 2, 48, 1024, 1, 2 * P, "R8 busy start");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    #2_000_000;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, errs + 1);
    $finish;
  end

endmodule